// File: doc/BRIEF.md
# Conversion Start Scheduler with Protected Read Window

This block paces an external converter that gives no end-of-conversion indication. It drives a periodic conversion-start strobe. The converter samples on the strobe's rising edge, and the high time and low time are programmed as separate cycle counts. The block raises a one-cycle interrupt when fresh data can be fetched. It also arbitrates requests from a serial reader, so that no transfer overlaps a conversion or the quiet guard interval that comes before each start edge.

Two pacing modes exist. In the wide mode the strobe stays high for the whole conversion, and its falling edge marks completion. In the narrow mode the strobe is a short pulse, the interrupt fires on its rising edge, and the block counts a separate conversion time before it admits reads. A reader asks with a level request and receives a one-cycle grant. It then reports its transfer with an activity level. If that level is seen inside a protected interval, a sticky fault flag is set.

Top module: `conv_sched`

## Requirements
- R1: While reset is asserted, and after reset until enabled, `conv_start`, `irq`, `rd_grant` and `viol` are all low.
- R2: After `enable` is first seen high on a clock edge, the strobe stays low for exactly `cfg_low` cycles and then rises.
- R3: While running, the strobe repeats with exactly `cfg_high` high cycles followed by `cfg_low` low cycles, with period `cfg_high + cfg_low` (both at least 1).
- R4: With `cfg_mode` = 0 (wide), the conversion occupies the `cfg_high` cycles of the high phase, and `irq` is high for exactly the one cycle in which the strobe has just fallen.
- R5: With `cfg_mode` = 1 (narrow), `irq` is high for exactly the one cycle in which the strobe has just risen, and the conversion occupies `cfg_conv` cycles counted from the rising edge.
- R6: Let p be the cycle position since the last rising edge (0 on the first high cycle). A request is granted with a one-cycle `rd_grant` in the cycle after a cycle where `rd_req` is high, `rd_active` and `rd_grant` are low, p is at least the conversion length, and (period − p) is at least `cfg_guard + cfg_rdlen + 1`. No grant is given during a conversion.
- R7: A request that is refused stays pending and is granted at the first position of the period that satisfies R6.
- R8: `viol` is set in the cycle after `rd_active` is high during a conversion, or at a position where (period − p) ≤ `cfg_guard`. It then stays set until `viol_clr` is sampled high with no new offence, and a new offence wins over a clear.
- R9: Configuration inputs are captured only while `enable` is low. Changes made while running leave the strobe timing, interrupt and grant behaviour unchanged.
- R10: When `enable` is sampled low, the strobe and interrupt are low and no grant is issued from the next cycle on. A later enable restarts with a full low phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Run control; configuration loads while low |
| cfg_mode | input | 1 | 0 wide strobe, 1 narrow pulse |
| cfg_high | input | W | Strobe high time in cycles |
| cfg_low | input | W | Strobe low time in cycles |
| cfg_conv | input | W | Conversion time in cycles (narrow mode) |
| cfg_guard | input | W | Quiet cycles before each rising edge |
| cfg_rdlen | input | W | Declared read length in cycles |
| rd_req | input | 1 | Reader asks to start a transfer |
| rd_active | input | 1 | Reader transfer in progress |
| viol_clr | input | 1 | Clears the fault flag |
| conv_start | output | 1 | Conversion-start strobe |
| irq | output | 1 | One-cycle data-ready interrupt |
| rd_grant | output | 1 | One-cycle read grant |
| viol | output | 1 | Sticky read-window fault |

## Verification
The embedded properties watch, on every cycle, the invariants of each stage. They check that the phase counter stays inside the period, that the strobe is low when a run starts, that interrupts and grants are single-cycle pulses, that no grant lands in a conversion or after disable, and that the fault flag only rises after reader activity and only drops on a clear. Exact cycle counts of the high and low phases and the mode-dependent interrupt edge can only be shown by the scenarios. The same holds for the precise grant position against guard and read length, for a pending request being served at the next legal slot, and for configuration changes during a run being ignored. For these, the bench predicts every output of every cycle from its own position count.

// File: rtl/conv_sched_pkg.sv
package conv_sched_pkg;
  typedef enum logic {
    MODE_WIDE   = 1'b0,
    MODE_NARROW = 1'b1
  } conv_mode_e;
endpackage

// File: rtl/cs_cfg_hold.sv
module cs_cfg_hold
  import conv_sched_pkg::*;
#(
  parameter int W         = 16,
  parameter int DEF_HIGH  = 738,
  parameter int DEF_LOW   = 738,
  parameter int DEF_CONV  = 738,
  parameter int DEF_GUARD = 63,
  parameter int DEF_RDLEN = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  conv_mode_e   mode_in,
  input  logic [W-1:0] high_in,
  input  logic [W-1:0] low_in,
  input  logic [W-1:0] conv_in,
  input  logic [W-1:0] guard_in,
  input  logic [W-1:0] rdlen_in,
  output conv_mode_e   mode_q,
  output logic [W-1:0] high_q,
  output logic [W-1:0] low_q,
  output logic [W-1:0] conv_q,
  output logic [W-1:0] guard_q,
  output logic [W-1:0] rdlen_q
);
  conv_mode_e   mode_d;
  logic [W-1:0] high_d, low_d, conv_d, guard_d, rdlen_d;

  // Next state: capture only while the scheduler is stopped (R9)
  always_comb begin
    mode_d  = mode_q;
    high_d  = high_q;
    low_d   = low_q;
    conv_d  = conv_q;
    guard_d = guard_q;
    rdlen_d = rdlen_q;
    if (load) begin
      mode_d  = mode_in;
      high_d  = high_in;
      low_d   = low_in;
      conv_d  = conv_in;
      guard_d = guard_in;
      rdlen_d = rdlen_in;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q  <= MODE_WIDE;
      high_q  <= W'(DEF_HIGH);
      low_q   <= W'(DEF_LOW);
      conv_q  <= W'(DEF_CONV);
      guard_q <= W'(DEF_GUARD);
      rdlen_q <= W'(DEF_RDLEN);
    end else begin
      mode_q  <= mode_d;
      high_q  <= high_d;
      low_q   <= low_d;
      conv_q  <= conv_d;
      guard_q <= guard_d;
      rdlen_q <= rdlen_d;
    end
  end

  p_frozen_when_running_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> ($stable(high_q) && $stable(low_q) && $stable(conv_q)
               && $stable(guard_q) && $stable(rdlen_q)));
endmodule

// File: rtl/cs_phase_gen.sv
module cs_phase_gen
  import conv_sched_pkg::*;
#(
  parameter int W  = 16,
  parameter int PW = W + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          enable,
  input  conv_mode_e    mode,
  input  logic [W-1:0]  high_cyc,
  input  logic [W-1:0]  low_cyc,
  input  logic [W-1:0]  conv_cyc,
  output logic          running,
  output logic          strobe,
  output logic          irq,
  output logic          busy,
  output logic [PW-1:0] to_edge
);
  logic          run_q, run_d;
  logic [PW-1:0] pos_q, pos_d;
  logic          strobe_q;
  logic [PW-1:0] period, high_ext, conv_len;

  assign high_ext = PW'(high_cyc);
  assign period   = high_ext + PW'(low_cyc);
  assign conv_len = (mode == MODE_NARROW) ? PW'(conv_cyc) : high_ext;

  // Position 0 is the first high cycle; a run starts at the low phase (R2)
  always_comb begin
    run_d = run_q;
    pos_d = pos_q;
    if (!enable) begin
      run_d = 1'b0;
      pos_d = '0;
    end else if (!run_q) begin
      run_d = 1'b1;
      pos_d = high_ext;
    end else if (pos_q >= period - PW'(1)) begin
      pos_d = '0;
    end else begin
      pos_d = pos_q + PW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q    <= 1'b0;
      pos_q    <= '0;
      strobe_q <= 1'b0;
    end else begin
      run_q    <= run_d;
      pos_q    <= pos_d;
      strobe_q <= strobe;
    end
  end

  assign running = run_q;
  assign strobe  = run_q && (pos_q < high_ext);
  assign busy    = run_q && (pos_q < conv_len);
  assign to_edge = period - pos_q;
  assign irq     = run_q && ((mode == MODE_NARROW) ? (strobe && !strobe_q)
                                                   : (!strobe && strobe_q));

  p_pos_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
    run_q |-> (pos_q < period));
  p_start_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(run_q) |-> !strobe);
  p_irq_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
    irq |=> !irq);
  p_idle_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !run_q |-> (!strobe && !irq && !busy));
endmodule

// File: rtl/cs_read_guard.sv
module cs_read_guard #(
  parameter int W  = 16,
  parameter int PW = W + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          enable,
  input  logic          running,
  input  logic          busy,
  input  logic [PW-1:0] to_edge,
  input  logic [W-1:0]  guard_cyc,
  input  logic [W-1:0]  rdlen_cyc,
  input  logic          rd_req,
  input  logic          rd_active,
  input  logic          viol_clr,
  output logic          rd_grant,
  output logic          viol
);
  localparam int SW = PW + 1;

  logic          grant_q, grant_d;
  logic          viol_q, viol_d;
  logic [SW-1:0] need, left;
  logic          fits, in_guard, offence;

  assign need     = SW'(guard_cyc) + SW'(rdlen_cyc) + SW'(1);
  assign left     = SW'(to_edge);
  assign fits     = running && !busy && (left >= need);
  assign in_guard = running && (left <= SW'(guard_cyc));
  assign offence  = rd_active && (busy || in_guard);

  always_comb begin
    grant_d = enable && fits && rd_req && !rd_active && !grant_q;  // R6, R7
    viol_d  = (viol_q && !viol_clr) || offence;                    // R8
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      grant_q <= 1'b0;
      viol_q  <= 1'b0;
    end else begin
      grant_q <= grant_d;
      viol_q  <= viol_d;
    end
  end

  assign rd_grant = grant_q;
  assign viol     = viol_q;

  p_grant_not_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rd_grant |-> !busy);
  p_grant_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rd_grant |=> !rd_grant);
  p_viol_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (viol && !viol_clr) |=> viol);
  p_viol_cause_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(viol) |-> $past(rd_active));
  p_off_no_grant_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> !rd_grant);
endmodule

// File: rtl/conv_sched.sv
module conv_sched
  import conv_sched_pkg::*;
#(
  parameter int W         = 16,
  parameter int DEF_HIGH  = 738,
  parameter int DEF_LOW   = 738,
  parameter int DEF_CONV  = 738,
  parameter int DEF_GUARD = 63,
  parameter int DEF_RDLEN = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         enable,
  input  logic         cfg_mode,
  input  logic [W-1:0] cfg_high,
  input  logic [W-1:0] cfg_low,
  input  logic [W-1:0] cfg_conv,
  input  logic [W-1:0] cfg_guard,
  input  logic [W-1:0] cfg_rdlen,
  input  logic         rd_req,
  input  logic         rd_active,
  input  logic         viol_clr,
  output logic         conv_start,
  output logic         irq,
  output logic         rd_grant,
  output logic         viol
);
  localparam int PW = W + 1;

  conv_mode_e    mode_q;
  logic [W-1:0]  high_q, low_q, conv_q, guard_q, rdlen_q;
  logic          running, busy;
  logic [PW-1:0] to_edge;

  cs_cfg_hold #(
    .W(W), .DEF_HIGH(DEF_HIGH), .DEF_LOW(DEF_LOW), .DEF_CONV(DEF_CONV),
    .DEF_GUARD(DEF_GUARD), .DEF_RDLEN(DEF_RDLEN)
  ) u_cfg (
    .clk(clk), .rst_n(rst_n), .load(!enable),
    .mode_in(conv_mode_e'(cfg_mode)), .high_in(cfg_high), .low_in(cfg_low),
    .conv_in(cfg_conv), .guard_in(cfg_guard), .rdlen_in(cfg_rdlen),
    .mode_q(mode_q), .high_q(high_q), .low_q(low_q), .conv_q(conv_q),
    .guard_q(guard_q), .rdlen_q(rdlen_q)
  );

  cs_phase_gen #(.W(W), .PW(PW)) u_phase (
    .clk(clk), .rst_n(rst_n), .enable(enable), .mode(mode_q),
    .high_cyc(high_q), .low_cyc(low_q), .conv_cyc(conv_q),
    .running(running), .strobe(conv_start), .irq(irq), .busy(busy),
    .to_edge(to_edge)
  );

  cs_read_guard #(.W(W), .PW(PW)) u_guard (
    .clk(clk), .rst_n(rst_n), .enable(enable), .running(running),
    .busy(busy), .to_edge(to_edge), .guard_cyc(guard_q),
    .rdlen_cyc(rdlen_q), .rd_req(rd_req), .rd_active(rd_active),
    .viol_clr(viol_clr), .rd_grant(rd_grant), .viol(viol)
  );

  p_reset_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !running |-> (!conv_start && !irq));
endmodule

// File: tb/sim_conv_sched.sv
module sim_conv_sched;
  localparam int W = 16;

  logic clk = 1'b0;
  logic rst_n;
  logic enable, cfg_mode, rd_req, rd_active, viol_clr;
  logic [W-1:0] cfg_high, cfg_low, cfg_conv, cfg_guard, cfg_rdlen;
  logic conv_start, irq, rd_grant, viol;

  always #4 clk = ~clk;

  conv_sched #(.W(W)) u0 (
    .clk(clk), .rst_n(rst_n), .enable(enable), .cfg_mode(cfg_mode),
    .cfg_high(cfg_high), .cfg_low(cfg_low), .cfg_conv(cfg_conv),
    .cfg_guard(cfg_guard), .cfg_rdlen(cfg_rdlen), .rd_req(rd_req),
    .rd_active(rd_active), .viol_clr(viol_clr), .conv_start(conv_start),
    .irq(irq), .rd_grant(rd_grant), .viol(viol)
  );

  int n_cmp = 0, n_bad = 0;
  bit done = 0;
  // model state
  int H, L, C, G, RL, P;
  bit M;
  bit run_m = 0;
  int s = 0;
  bit e_strobe = 0, e_irq = 0, e_grant = 0, e_viol = 0;
  bit nx_en = 0, nx_clr = 0, rogue = 0, first_low = 0, cfg_moved = 0;
  int rd_left = 0;

  task automatic chk(input string tag, input logic act, input logic exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0b expected %0b at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic bit slot_ok(int p);
    int cl;
    cl = M ? C : H;
    return (p >= cl) && ((P - p) >= G + RL + 1);
  endfunction

  task automatic step();
    bit g_n, v_n, str_cur;
    int cl;
    @(negedge clk);
    if (!e_strobe && conv_start && first_low) first_low = 0;
    chk(cfg_moved ? "R9 strobe" : (first_low ? "R2 strobe" : "R3 strobe"), conv_start, e_strobe);
    chk(M ? "R5 irq" : "R4 irq", irq, e_irq);
    chk(cfg_moved ? "R9 grant" : "R6/R7 grant", rd_grant, e_grant);
    chk("R8 viol", viol, e_viol);
    if (e_strobe) first_low = 0;
    // apply controls
    enable = nx_en;
    viol_clr = nx_clr;
    if (rogue) begin rd_active = 1; rd_req = 0; rd_left = 0; end
    else if (rd_left > 0) begin rd_active = 1; rd_left--; end
    else if (rd_grant) begin rd_req = 0; rd_active = 1; rd_left = RL - 1; end
    else begin
      rd_active = 0;
      if (!rd_req && $urandom_range(0, 7) == 0) rd_req = 1;
    end
    // predict next sample
    cl = M ? C : H;
    g_n = run_m && enable && rd_req && !rd_active && !e_grant && slot_ok(s);
    v_n = (e_viol && !viol_clr) || (run_m && rd_active && ((s < cl) || (P - s <= G)));
    str_cur = e_strobe;
    if (!enable) begin run_m = 0; s = 0; end
    else if (!run_m) begin run_m = 1; s = H; end
    else s = (s + 1) % P;
    e_strobe = run_m && (s < H);
    e_irq = run_m && (M ? (e_strobe && !str_cur) : (!e_strobe && str_cur));
    e_grant = g_n;
    e_viol = v_n;
  endtask

  task automatic run_case(int h, int l, int c, int g, int rl, bit m, int ncyc,
                          bit do_rogue, bit do_move);
    cfg_high = W'(h); cfg_low = W'(l); cfg_conv = W'(c);
    cfg_guard = W'(g); cfg_rdlen = W'(rl); cfg_mode = m;
    nx_en = 0; nx_clr = 0;
    step(); step();
    H = h; L = l; C = c; G = g; RL = rl; M = m; P = h + l;
    nx_en = 1; first_low = 1;
    for (int i = 0; i < ncyc; i++) begin
      if (do_move && i == ncyc / 3) begin
        // R9: scramble configuration while running
        cfg_high = W'(h + 3); cfg_low = W'(l + 5); cfg_mode = !m;
        cfg_guard = W'(0); cfg_rdlen = W'(1); cfg_conv = W'(1);
        cfg_moved = 1;
      end
      if (do_rogue && i == ncyc / 2) rogue = 1;
      if (do_rogue && i == ncyc / 2 + 2 * P) rogue = 0;
      nx_clr = do_rogue && (i == ncyc / 2 + 2 * P + 4);
      step();
    end
    nx_clr = 0; rogue = 0;
    // R10: stop, then check quiet outputs
    nx_en = 0;
    for (int i = 0; i < 4; i++) step();
    cfg_moved = 0;
    // clear sticky state for next case
    nx_clr = 1; step(); nx_clr = 0; step();
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual running expected finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4711));
    rst_n = 0; enable = 0; cfg_mode = 0; rd_req = 0; rd_active = 0; viol_clr = 0;
    cfg_high = 6; cfg_low = 10; cfg_conv = 4; cfg_guard = 2; cfg_rdlen = 3;
    H = 6; L = 10; C = 4; G = 2; RL = 3; M = 0; P = 16;
    @(negedge clk);
    chk("R1 strobe", conv_start, 1'b0);
    chk("R1 irq", irq, 1'b0);
    chk("R1 grant", rd_grant, 1'b0);
    chk("R1 viol", viol, 1'b0);
    rst_n = 1;
    step(); step();
    // directed: wide mode, uneven duty
    run_case(6, 10, 4, 2, 3, 0, 120, 0, 0);
    // directed: 50:50 wide
    run_case(12, 12, 1, 3, 4, 0, 150, 0, 0);
    // directed: narrow pulse with separate conversion time
    run_case(2, 20, 8, 3, 4, 1, 150, 0, 0);
    // R8: offending reader, then clear
    run_case(5, 9, 3, 2, 2, 0, 160, 1, 0);
    // R9: configuration moved during run
    run_case(4, 11, 6, 1, 2, 1, 150, 0, 1);
    // tight corner: guard plus read exactly fills the low phase
    run_case(3, 8, 2, 3, 4, 0, 100, 0, 0);
    // constrained random
    for (int k = 0; k < 12; k++) begin
      int h, l;
      h = $urandom_range(1, 10);
      l = $urandom_range(1, 14);
      run_case(h, l, $urandom_range(1, h + l), $urandom_range(0, 4),
               $urandom_range(1, 5), 1'($urandom_range(0, 1)), 200,
               $urandom_range(0, 3) == 0, $urandom_range(0, 3) == 0);
    end
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule